// File: doc/BRIEF.md
# Two-Rail Code Checker Tree

This block watches a bundle of complementary signal pairs and reports when any of them has lost its complementary relation. Each monitored pair carries a "true" rail and a "false" rail. While the pair is healthy the false rail is the inverse of the true rail. A pair whose rails agree (both 0 or both 1) is a fault. The pairs are folded together by a tree of two-input checker cells. Each cell turns two healthy pairs into one healthy pair and turns any faulty input into a faulty output. The root of the tree is therefore a single pair that is complementary exactly when every input pair is.

A build-time option replaces the tree with a cheaper form. Each pair is XORed across its rails. The result goes through an implication stage whose second operand is tied low, which gives one fault flag per pair. The flags are then ORed. In this form the output pair is a fixed code word (1, 0) while all pairs are healthy and collapses to (0, 0) on a fault. The same decoded error output therefore works for both variants.

The root pair is captured in an output register. A small control unit arms that register one cycle after reset is released, so the first value captured after reset comes from inputs that were fully driven.

Top module: `rail_chk_top`

## Requirements
- R1: A pair i is healthy when railY[i] equals the inverse of railX[i]. When every pair is healthy, errorFlag reads 0.
- R2: If one or more pairs have railX[i] equal to railY[i], errorFlag reads 1. This holds whatever the number and position of the faulty pairs.
- R3: In the tree variant (REDUCED=0) with all pairs healthy, sumRail equals the XOR of all railX bits and compRail equals its inverse. This follows from each cell computing e1 = x0&y1 | y0&x1 and e2 = x0&x1 | y0&y1.
- R4: When NUM_PAIRS is not a power of two, the unused tree leaves are filled with the healthy pair (x=0, y=1). The result of R1 to R3 is then the same as for the real pairs alone.
- R5: errorFlag is 1 exactly when sumRail equals compRail.
- R6: In the reduced variant (REDUCED=1), sumRail=1 and compRail=0 while all pairs are healthy. On any fault, sumRail=0, compRail=0 and errorFlag=1.
- R7: While rstN is low, the outputs hold sumRail=0, compRail=1, errorFlag=0. After rstN rises, the first clock edge only arms the register. From then on, each clock edge captures the current inputs, so an input change shows at the outputs after the next rising edge.
- R8: The outputs depend only on the inputs captured at the last edge. A fault that is removed leaves no trace once healthy inputs have been captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Active-low asynchronous reset |
| railX | input | NUM_PAIRS | True rail of each monitored pair |
| railY | input | NUM_PAIRS | False rail of each monitored pair |
| sumRail | output | 1 | First rail of the registered root pair |
| compRail | output | 1 | Second rail of the registered root pair |
| errorFlag | output | 1 | High when the root pair is not complementary |

## Verification
The assertions assume that the rail inputs settle before the clock edge that captures them. They also compare each output with the inputs sampled one edge earlier, from the second edge after reset release onward. The stimulus meets this by changing the rails only on the falling clock edge. It reads the outputs on the following falling edge, after one rising edge has passed. The sweep covers every one of the 4^5 rail combinations for five pairs. This drives both healthy and faulty codes into the padded tree and the reduced variant side by side.

// File: rtl/rail_chk_pkg.sv
`timescale 1ns/1ps
package rail_chk_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic loadResult;   // capture the root pair this edge
    logic clearResult;  // force the healthy reset code
  } ctlStrobe_t;

  // value held by the output register while cleared
  localparam logic RESET_SUM  = 1'b0;
  localparam logic RESET_COMP = 1'b1;

endpackage

// File: rtl/rail_chk_cell.sv
`timescale 1ns/1ps
// Two-pair checker cell: healthy in -> healthy out, any bad pair -> bad out.
module rail_chk_cell (
  input  logic x0,
  input  logic y0,
  input  logic x1,
  input  logic y1,
  output logic e1,
  output logic e2
);
  assign e1 = (x0 & y1) | (y0 & x1);
  assign e2 = (x0 & x1) | (y0 & y1);
endmodule

// File: rtl/rail_chk_ctrl.sv
`timescale 1ns/1ps
module rail_chk_ctrl
  import rail_chk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  output ctlStrobe_t strobe
);
  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  always_comb begin
    strobe.loadResult  = armed;
    strobe.clearResult = ~armed;
  end
endmodule

// File: rtl/rail_chk_dp.sv
`timescale 1ns/1ps
module rail_chk_dp
  import rail_chk_pkg::*;
#(
  parameter int NUM_PAIRS = 8,
  parameter bit REDUCED   = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           strobe,
  input  logic [NUM_PAIRS-1:0] railX,
  input  logic [NUM_PAIRS-1:0] railY,
  output logic                 sumRail,
  output logic                 compRail,
  output logic                 errorFlag
);
  localparam int LEVELS = (NUM_PAIRS <= 1) ? 0 : $clog2(NUM_PAIRS);
  localparam int LEAVES = 1 << LEVELS;

  logic combSum;
  logic combComp;

  generate
    if (REDUCED) begin : g_reduced
      logic [NUM_PAIRS-1:0] flagVec;
      for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_flag
        logic crossXor;
        assign crossXor   = railX[i] ^ railY[i];
        // implication with the second operand tied low
        assign flagVec[i] = ~crossXor | 1'b0;
      end
      assign combSum  = ~(|flagVec);
      assign combComp = 1'b0;
    end else begin : g_tree
      wire [LEAVES-1:0] lvlX [0:LEVELS];
      wire [LEAVES-1:0] lvlY [0:LEVELS];
      for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < NUM_PAIRS) begin : g_real
          assign lvlX[0][i] = railX[i];
          assign lvlY[0][i] = railY[i];
        end else begin : g_pad
          assign lvlX[0][i] = 1'b0;
          assign lvlY[0][i] = 1'b1;
        end
      end
      for (genvar l = 0; l < LEVELS; l++) begin : g_level
        localparam int NODES = LEAVES >> (l + 1);
        for (genvar j = 0; j < NODES; j++) begin : g_node
          rail_chk_cell uCell (
            .x0(lvlX[l][2*j]),   .y0(lvlY[l][2*j]),
            .x1(lvlX[l][2*j+1]), .y1(lvlY[l][2*j+1]),
            .e1(lvlX[l+1][j]),   .e2(lvlY[l+1][j])
          );
        end
        for (genvar k = NODES; k < LEAVES; k++) begin : g_idle
          assign lvlX[l+1][k] = 1'b0;
          assign lvlY[l+1][k] = 1'b1;
        end
      end
      assign combSum  = lvlX[LEVELS][0];
      assign combComp = lvlY[LEVELS][0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumRail  <= RESET_SUM;
      compRail <= RESET_COMP;
    end else if (strobe.clearResult) begin
      sumRail  <= RESET_SUM;
      compRail <= RESET_COMP;
    end else if (strobe.loadResult) begin
      sumRail  <= combSum;
      compRail <= combComp;
    end
  end

  assign errorFlag = ~(sumRail ^ compRail);
endmodule

// File: rtl/rail_chk_top.sv
`timescale 1ns/1ps
module rail_chk_top
  import rail_chk_pkg::*;
#(
  parameter int NUM_PAIRS = 8,
  parameter bit REDUCED   = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PAIRS-1:0] railX,
  input  logic [NUM_PAIRS-1:0] railY,
  output logic                 sumRail,
  output logic                 compRail,
  output logic                 errorFlag
);
  ctlStrobe_t strobe;

  rail_chk_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .strobe(strobe)
  );

  rail_chk_dp #(.NUM_PAIRS(NUM_PAIRS), .REDUCED(REDUCED)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .railX(railX), .railY(railY),
    .sumRail(sumRail), .compRail(compRail), .errorFlag(errorFlag)
  );
endmodule

// File: rtl/rail_chk_sva.sv
`timescale 1ns/1ps
module rail_chk_sva #(
  parameter int NUM_PAIRS = 8,
  parameter bit REDUCED   = 1'b0
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_PAIRS-1:0] railX,
  input logic [NUM_PAIRS-1:0] railY,
  input logic                 sumRail,
  input logic                 compRail,
  input logic                 errorFlag
);
  logic allOk;
  assign allOk = &(railX ^ railY);

  AST_HEALTHY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN, 2) && $past(allOk) |-> !errorFlag);  // R1

  AST_FAULT_SEEN: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN, 2) && !$past(allOk) |-> errorFlag);  // R2

  AST_NO_MEMORY: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN, 3) && ($past(railX) == $past(railX, 2)) && ($past(railY) == $past(railY, 2))
    |-> $stable({sumRail, compRail, errorFlag}));  // R8

  generate
    if (REDUCED) begin : g_red
      AST_REDUCED_CODE: assert property (@(posedge clk) disable iff (!rstN)
        $past(rstN, 2) && $past(allOk) |-> sumRail && !compRail);  // R6
      AST_REDUCED_FAULT: assert property (@(posedge clk) disable iff (!rstN)
        $past(rstN, 2) && !$past(allOk) |-> !sumRail && !compRail);  // R6
    end else begin : g_tree
      AST_PARITY_RAILS: assert property (@(posedge clk) disable iff (!rstN)
        $past(rstN, 2) && $past(allOk) |-> (sumRail == $past(^railX)) && (compRail != sumRail));  // R3
    end
  endgenerate
endmodule

bind rail_chk_top rail_chk_sva #(.NUM_PAIRS(NUM_PAIRS), .REDUCED(REDUCED)) uSva (
  .clk(clk), .rstN(rstN), .railX(railX), .railY(railY),
  .sumRail(sumRail), .compRail(compRail), .errorFlag(errorFlag)
);

// File: tb/sim_rail_chk_top.sv
`timescale 1ns/1ps
module sim_rail_chk_top;
  localparam int NP = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NP-1:0] railX = '0;
  logic [NP-1:0] railY = '0;
  logic sum0, comp0, err0;
  logic sum1, comp1, err1;
  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rail_chk_top #(.NUM_PAIRS(NP), .REDUCED(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .railX(railX), .railY(railY),
    .sumRail(sum0), .compRail(comp0), .errorFlag(err0)
  );

  rail_chk_top #(.NUM_PAIRS(NP), .REDUCED(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .railX(railX), .railY(railY),
    .sumRail(sum1), .compRail(comp1), .errorFlag(err1)
  );

  task automatic checkBit(input string tag, input logic got, input logic exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // drive on falling edge, let one rising edge pass, sample on next falling edge
  task automatic applyAndWait(input logic [NP-1:0] xv, input logic [NP-1:0] yv);
    railX = xv;
    railY = yv;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkAll(input logic [NP-1:0] xv, input logic [NP-1:0] yv);
    logic healthy;
    logic par;
    healthy = &(xv ^ yv);
    par = ^xv;
    if (healthy) begin
      checkBit("R1 tree error", err0, 1'b0);
      checkBit("R3 R4 tree sumRail parity", sum0, par);
      checkBit("R3 R4 tree compRail", comp0, ~par);
      checkBit("R6 reduced healthy sum", sum1, 1'b1);
      checkBit("R6 reduced healthy comp", comp1, 1'b0);
      checkBit("R1 reduced error", err1, 1'b0);
    end else begin
      checkBit("R2 tree error", err0, 1'b1);
      checkBit("R5 tree rails equal", sum0 == comp0, 1'b1);
      checkBit("R6 reduced fault sum", sum1, 1'b0);
      checkBit("R6 reduced fault comp", comp1, 1'b0);
      checkBit("R2 reduced error", err1, 1'b1);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] xv;
    logic [NP-1:0] yv;
    repeat (3) @(negedge clk);
    // R7 reset state
    checkBit("R7 reset sum", sum0, 1'b0);
    checkBit("R7 reset comp", comp0, 1'b1);
    checkBit("R7 reset error", err0, 1'b0);
    railX = 5'b00000;
    railY = 5'b00000;  // faulty while arming
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    checkBit("R7 arming edge holds reset code", err0, 1'b0);
    @(posedge clk);
    @(negedge clk);
    checkBit("R7 first capture shows fault", err0, 1'b1);

    // exhaustive sweep over all rail codes
    for (int code = 0; code < (1 << (2 * NP)); code++) begin
      for (int i = 0; i < NP; i++) begin
        xv[i] = code[2*i];
        yv[i] = code[2*i+1];
      end
      applyAndWait(xv, yv);
      checkAll(xv, yv);
    end

    // R7 latency: change is invisible before the rising edge
    applyAndWait(5'b10110, 5'b01001);
    railX = 5'b10110;
    railY = 5'b01011;  // pair 1 faulty
    #1;
    checkBit("R7 no change before edge", err0, 1'b0);
    @(posedge clk);
    @(negedge clk);
    checkBit("R7 change after edge", err0, 1'b1);

    // R8 fault cleared leaves no trace
    applyAndWait(5'b10110, 5'b01001);
    checkBit("R8 tree error cleared", err0, 1'b0);
    checkBit("R8 reduced error cleared", err1, 1'b0);
    checkBit("R8 tree parity after clear", sum0, 1'b1);

    // R7 reset mid-run while faulty
    railY = 5'b11001;
    rstN = 1'b0;
    #1;
    checkBit("R7 async reset sum", sum0, 1'b0);
    checkBit("R7 async reset comp", comp0, 1'b1);
    checkBit("R7 async reset reduced error", err1, 1'b0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule